// File: doc/BRIEF.md
# Point-Plot Display Command Decoder

This block sits between a 12-bit processor's programmed I/O path and a point-plot display. On every I/O strobe it inspects the instruction word. If the word is an I/O transfer aimed at the display's device code, the block carries out one of eight sub-operations. These load the horizontal or vertical coordinate, fire an intensify pulse, load or read back the enable register, test or clear the done flag, or clear the display logic.

The block also answers the processor during the strobe cycle itself. It raises a skip request, raises an accumulator-clear request and drives read-back data. A separate timing unit owns the done flag. This block only reads that flag. It sends the timing unit three requests: a done-clear pulse, a coordinate-start pulse and an enable-load pulse. The coordinate registers and control bits drive the display converters and control lines directly. An interrupt request is derived from the done flag and the interrupt-enable bit.

Top module: `plotCmdIf`

## Requirements
- R1: The block acts on an instruction only while `ioStrobe` is high, `instr[11:9]` is 3'b110 and `instr[8:3]` equals the device code. The device code is octal 05 when `altDevSel` is 0 and octal 15 when it is 1. Any other strobed word changes no register and raises none of `skip`, `accClear`, `rdValid`, `doneClr`, `coordStart`, `enableLoad` or `intensify`.
- R2: While `rstN` is low at a clock edge, `xCoord`, `yCoord` and all six enable bits become zero.
- R3: Sub-operation 0 (`instr[2:0]`=0) zeroes all six enable bits at the next edge and raises `doneClr` during the strobe. Both coordinates are left unchanged.
- R4: Sub-operation 1 raises `doneClr` during the strobe and leaves the coordinates and enable bits unchanged.
- R5: Sub-operation 2 drives `skip` equal to `doneIn` during the strobe. It does not raise `doneClr`.
- R6: Sub-operations 3 and 4 load `accIn[9:0]` into `xCoord` and `yCoord` respectively at the next edge and raise `coordStart`. Bits 11:10 are dropped and `accClear` stays low.
- R7: Sub-operation 5 raises `intensify` during the strobe and changes no register.
- R8: Sub-operation 6 raises `accClear` and `enableLoad` during the strobe. At the next edge it loads the enable bits from the accumulator: `writeThru`=`accIn[5]`, `storeMode`=`accIn[4]`, `eraseReq`=`accIn[3]`, `colorSel`=`accIn[2]`, `chanSel`=`accIn[1]`, `intEnable`=`accIn[0]`. `accIn[11:6]` has no effect.
- R9: Sub-operation 7 raises `rdValid` and drives `rdData` = {`doneIn`, 5'b0, `writeThru`, `storeMode`, 1'b0, `colorSel`, `chanSel`, `intEnable`}. The erase bit (`rdData[3]`) always reads zero. When `rdValid` is low, `rdData` is zero.
- R10: `irq` is high exactly when `doneIn` and `intEnable` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ioStrobe | input | 1 | I/O transfer strobe, one cycle per instruction |
| instr | input | 12 | Instruction word |
| accIn | input | 12 | Accumulator value |
| altDevSel | input | 1 | Selects the alternate device code 15 instead of 05 |
| doneIn | input | 1 | Done flag held by the timing unit |
| skip | output | 1 | Skip request to the processor |
| accClear | output | 1 | Accumulator-clear request |
| rdValid | output | 1 | Read-back data is valid |
| rdData | output | 12 | Read-back data for the accumulator |
| xCoord | output | 10 | Horizontal coordinate, two's complement |
| yCoord | output | 10 | Vertical coordinate, two's complement |
| writeThru | output | 1 | Defocused non-storing write control |
| storeMode | output | 1 | Storage mode control |
| eraseReq | output | 1 | Erase request |
| colorSel | output | 1 | Color select |
| chanSel | output | 1 | Display channel / pen select |
| intEnable | output | 1 | Interrupt enable bit |
| irq | output | 1 | Interrupt request |
| doneClr | output | 1 | Pulse asking the timing unit to clear done |
| coordStart | output | 1 | Pulse starting the settling timer after a coordinate load |
| enableLoad | output | 1 | Pulse telling the timer that the enable register was written |
| intensify | output | 1 | Intensify request pulse |

## Verification
Directed words first cover each sub-operation at both code settings. Next come near-miss words: device 04, device 15 with the main code selected, and a non-transfer opcode. These separate a correct device compare from one that is too loose. All-ones accumulator loads show that coordinate truncation and enable-field positions are right. Read-backs taken with the done flag at both values show that erase masking and done mirroring are kept apart. A long random mix of matching and foreign words, accumulators and done values then checks that no sub-operation disturbs state owned by another.

// File: rtl/plotPkg.sv
package plotPkg;

  typedef enum logic [2:0] {
    OP_CLR_ALL   = 3'd0,
    OP_CLR_DONE  = 3'd1,
    OP_SKIP_DONE = 3'd2,
    OP_LOAD_X    = 3'd3,
    OP_LOAD_Y    = 3'd4,
    OP_INTENS    = 3'd5,
    OP_LOAD_EN   = 3'd6,
    OP_READ_EN   = 3'd7
  } plotOpT;

  typedef struct packed {
    logic clrAll;
    logic clrDone;
    logic testSkip;
    logic ldX;
    logic ldY;
    logic intens;
    logic ldEn;
    logic rdEn;
  } plotStrobeT;

  // Field order matches accumulator bits 5..0
  typedef struct packed {
    logic wt;
    logic st;
    logic er;
    logic co;
    logic ch;
    logic ie;
  } plotEnableT;

  localparam int ENABLE_W = $bits(plotEnableT);

endpackage

// File: rtl/plotCtrl.sv
module plotCtrl
  import plotPkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int DEV_W    = 6,
  parameter int OP_W     = 3,
  parameter logic [DEV_W-1:0] DEV_MAIN = 6'o05,
  parameter logic [DEV_W-1:0] DEV_ALT  = 6'o15
) (
  input  logic              ioStrobe,
  input  logic [WORD_W-1:0] instr,
  input  logic              altDevSel,
  output plotStrobeT        strobes
);
  localparam int CLASS_W = WORD_W - DEV_W - OP_W;
  localparam logic [CLASS_W-1:0] IOT_CLASS = 3'b110;

  logic [CLASS_W-1:0] classField;
  logic [DEV_W-1:0]   devField;
  logic [DEV_W-1:0]   devWanted;
  plotOpT             opField;
  logic               devHit;

  assign classField = instr[WORD_W-1 -: CLASS_W];
  assign devField   = instr[OP_W +: DEV_W];
  assign opField    = plotOpT'(instr[OP_W-1:0]);
  assign devWanted  = altDevSel ? DEV_ALT : DEV_MAIN;
  assign devHit     = ioStrobe && (classField == IOT_CLASS) && (devField == devWanted);

  always_comb begin
    strobes = '0;
    if (devHit) begin
      unique case (opField)
        OP_CLR_ALL:   strobes.clrAll   = 1'b1;
        OP_CLR_DONE:  strobes.clrDone  = 1'b1;
        OP_SKIP_DONE: strobes.testSkip = 1'b1;
        OP_LOAD_X:    strobes.ldX      = 1'b1;
        OP_LOAD_Y:    strobes.ldY      = 1'b1;
        OP_INTENS:    strobes.intens   = 1'b1;
        OP_LOAD_EN:   strobes.ldEn     = 1'b1;
        OP_READ_EN:   strobes.rdEn     = 1'b1;
        default:      strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/plotDatapath.sv
module plotDatapath
  import plotPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  plotStrobeT         strobes,
  input  logic [WORD_W-1:0]  accIn,
  input  logic               doneIn,
  output logic [COORD_W-1:0] xCoord,
  output logic [COORD_W-1:0] yCoord,
  output plotEnableT         enBits,
  output logic               skip,
  output logic               accClear,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData,
  output logic               doneClr,
  output logic               coordStart,
  output logic               enableLoad,
  output logic               intensify,
  output logic               irq
);
  logic [COORD_W-1:0] xReg, yReg;
  plotEnableT         enReg;
  logic [WORD_W-1:0]  readWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
    end else begin
      if (strobes.ldX) xReg <= accIn[COORD_W-1:0];
      if (strobes.ldY) yReg <= accIn[COORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrAll) enReg <= '0;
    else if (strobes.ldEn)       enReg <= plotEnableT'(accIn[ENABLE_W-1:0]);
  end

  // Read-back: done mirrored at the top bit, erase masked
  always_comb begin
    readWord           = '0;
    readWord[WORD_W-1] = doneIn;
    readWord[ENABLE_W-1:0] = {enReg.wt, enReg.st, 1'b0, enReg.co, enReg.ch, enReg.ie};
  end

  assign rdData     = strobes.rdEn ? readWord : '0;
  assign rdValid    = strobes.rdEn;
  assign skip       = strobes.testSkip && doneIn;
  assign accClear   = strobes.ldEn;
  assign doneClr    = strobes.clrAll || strobes.clrDone;
  assign coordStart = strobes.ldX || strobes.ldY;
  assign enableLoad = strobes.ldEn;
  assign intensify  = strobes.intens;
  assign irq        = doneIn && enReg.ie;
  assign xCoord     = xReg;
  assign yCoord     = yReg;
  assign enBits     = enReg;

endmodule

// File: rtl/plotCmdIf.sv
module plotCmdIf
  import plotPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int COORD_W = 10,
  parameter logic [5:0] DEV_MAIN = 6'o05,
  parameter logic [5:0] DEV_ALT  = 6'o15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioStrobe,
  input  logic [WORD_W-1:0]  instr,
  input  logic [WORD_W-1:0]  accIn,
  input  logic               altDevSel,
  input  logic               doneIn,
  output logic               skip,
  output logic               accClear,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData,
  output logic [COORD_W-1:0] xCoord,
  output logic [COORD_W-1:0] yCoord,
  output logic               writeThru,
  output logic               storeMode,
  output logic               eraseReq,
  output logic               colorSel,
  output logic               chanSel,
  output logic               intEnable,
  output logic               irq,
  output logic               doneClr,
  output logic               coordStart,
  output logic               enableLoad,
  output logic               intensify
);
  plotStrobeT strobes;
  plotEnableT enBits;

  plotCtrl #(
    .WORD_W(WORD_W), .DEV_W(6), .OP_W(3),
    .DEV_MAIN(DEV_MAIN), .DEV_ALT(DEV_ALT)
  ) uCtrl (
    .ioStrobe(ioStrobe), .instr(instr), .altDevSel(altDevSel), .strobes(strobes)
  );

  plotDatapath #(.WORD_W(WORD_W), .COORD_W(COORD_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accIn(accIn), .doneIn(doneIn),
    .xCoord(xCoord), .yCoord(yCoord), .enBits(enBits),
    .skip(skip), .accClear(accClear), .rdValid(rdValid), .rdData(rdData),
    .doneClr(doneClr), .coordStart(coordStart), .enableLoad(enableLoad),
    .intensify(intensify), .irq(irq)
  );

  assign writeThru = enBits.wt;
  assign storeMode = enBits.st;
  assign eraseReq  = enBits.er;
  assign colorSel  = enBits.co;
  assign chanSel   = enBits.ch;
  assign intEnable = enBits.ie;

endmodule

// File: rtl/plotCmdChecker.sv
module plotCmdChecker (
  input logic        clk,
  input logic        rstN,
  input logic        ioStrobe,
  input logic [11:0] instr,
  input logic [11:0] accIn,
  input logic        altDevSel,
  input logic        doneIn,
  input logic        skip,
  input logic        accClear,
  input logic        rdValid,
  input logic [11:0] rdData,
  input logic [9:0]  xCoord,
  input logic [9:0]  yCoord,
  input logic        writeThru,
  input logic        storeMode,
  input logic        eraseReq,
  input logic        colorSel,
  input logic        chanSel,
  input logic        intEnable,
  input logic        irq,
  input logic        doneClr,
  input logic        coordStart,
  input logic        enableLoad,
  input logic        intensify
);
  logic       hit;
  logic [2:0] op;
  logic [5:0] ctl;

  assign hit = ioStrobe && instr[11:9] == 3'b110 &&
               instr[8:3] == (altDevSel ? 6'o15 : 6'o05);
  assign op  = instr[2:0];
  assign ctl = {writeThru, storeMode, eraseReq, colorSel, chanSel, intEnable};

  p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ioStrobe && !hit) |-> !(skip || accClear || rdValid || doneClr ||
                             coordStart || enableLoad || intensify));

  p_foreign_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ioStrobe && !hit) |=> ($stable(xCoord) && $stable(yCoord) && $stable(ctl)));

  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hit && op == 3'd0) |=> (ctl == 6'd0 && $stable(xCoord) && $stable(yCoord)));

  p_skip_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && op == 3'd2) |-> (skip == doneIn && !doneClr));

  p_load_x_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && op == 3'd3) |=> (xCoord == $past(accIn[9:0])));

  p_load_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hit && op == 3'd6) |-> (accClear && enableLoad));

  p_read_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[3] == 1'b0 && rdData[10:6] == 5'd0 && rdData[11] == doneIn));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq == (doneIn && intEnable));

endmodule

bind plotCmdIf plotCmdChecker uChk (.*);

// File: tb/tb_plotCmdIf.sv
`timescale 1ns/1ps
module tb_plotCmdIf;
  logic        clk = 1'b0;
  logic        rstN, ioStrobe, altDevSel, doneIn;
  logic [11:0] instr, accIn;
  logic        skip, accClear, rdValid, irq, doneClr, coordStart, enableLoad, intensify;
  logic [11:0] rdData;
  logic [9:0]  xCoord, yCoord;
  logic        writeThru, storeMode, eraseReq, colorSel, chanSel, intEnable;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  logic [9:0] xM, yM;
  logic [5:0] enM;

  always #2.5 clk = ~clk;

  plotCmdIf dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic isHit(input logic [11:0] w, input logic alt);
    return w[11:9] == 3'b110 && w[8:3] == (alt ? 6'o15 : 6'o05);
  endfunction

  function automatic string tagFor(input logic hit, input logic [2:0] op);
    if (!hit) return "R1";
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [11:0] readModel(input logic d, input logic [5:0] e);
    return {d, 5'b0, e[5], e[4], 1'b0, e[2], e[1], e[0]};
  endfunction

  task automatic doOp(input logic [11:0] w, input logic [11:0] acc, input logic alt, input logic d);
    logic h;
    logic [2:0] op;
    string t;
    h = isHit(w, alt);
    op = w[2:0];
    t = tagFor(h, op);
    @(negedge clk);
    instr = w; accIn = acc; altDevSel = alt; doneIn = d; ioStrobe = 1'b1;
    #1;
    chk(t, "skip", skip, h && op == 3'd2 && d);
    chk(t, "accClear", accClear, h && op == 3'd6);
    chk(t, "rdValid", rdValid, h && op == 3'd7);
    chk(t, "rdData", rdData, (h && op == 3'd7) ? readModel(d, enM) : 12'd0);
    chk(t, "doneClr", doneClr, h && (op == 3'd0 || op == 3'd1));
    chk(t, "coordStart", coordStart, h && (op == 3'd3 || op == 3'd4));
    chk(t, "enableLoad", enableLoad, h && op == 3'd6);
    chk(t, "intensify", intensify, h && op == 3'd5);
    chk("R10", "irq", irq, d && enM[0]);
    @(posedge clk);
    if (h) begin
      case (op)
        3'd0: enM = '0;
        3'd3: xM = acc[9:0];
        3'd4: yM = acc[9:0];
        3'd6: enM = acc[5:0];
        default: ;
      endcase
    end
    #1;
    ioStrobe = 1'b0;
    chk(t, "xCoord", xCoord, xM);
    chk(t, "yCoord", yCoord, yM);
    chk(t, "enable", {writeThru, storeMode, eraseReq, colorSel, chanSel, intEnable}, enM);
  endtask

  function automatic logic [11:0] mk(input logic [5:0] dev, input logic [2:0] op);
    return {3'b110, dev, op};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rstN = 1'b0; ioStrobe = 1'b0; instr = '0; accIn = '0; altDevSel = 1'b0; doneIn = 1'b0;
    xM = '0; yM = '0; enM = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "xCoord after reset", xCoord, 0);
    chk("R2", "yCoord after reset", yCoord, 0);
    chk("R2", "enable after reset",
        {writeThru, storeMode, eraseReq, colorSel, chanSel, intEnable}, 0);
    @(negedge clk); rstN = 1'b1;

    // Directed corners
    doOp(mk(6'o05, 3'd3), 12'hFFF, 0, 0);        // R6 truncation
    doOp(mk(6'o05, 3'd4), 12'h801, 0, 0);        // R6
    doOp(mk(6'o05, 3'd6), 12'hFFF, 0, 0);        // R8 all bits
    doOp(mk(6'o05, 3'd7), 12'h000, 0, 1);        // R9 erase masked, done=1
    doOp(mk(6'o05, 3'd7), 12'h000, 0, 0);        // R9 done=0
    doOp(mk(6'o05, 3'd2), 12'h000, 0, 1);        // R5
    doOp(mk(6'o05, 3'd2), 12'h000, 0, 0);        // R5
    doOp(mk(6'o05, 3'd1), 12'h000, 0, 1);        // R4
    doOp(mk(6'o04, 3'd3), 12'h123, 0, 1);        // R1 wrong device
    doOp(mk(6'o15, 3'd0), 12'h000, 0, 1);        // R1 alt code not selected
    doOp({3'b111, 6'o05, 3'd6}, 12'h000, 0, 1);  // R1 not a transfer opcode
    doOp(mk(6'o15, 3'd3), 12'h2AA, 1, 0);        // R1 alt code selected
    doOp(mk(6'o05, 3'd3), 12'h155, 1, 0);        // R1 main code while alt selected
    doOp(mk(6'o05, 3'd5), 12'h000, 0, 0);        // R7
    doOp(mk(6'o05, 3'd6), 12'hFC1, 0, 1);        // R8 high bits ignored, R10 irq
    doOp(mk(6'o05, 3'd0), 12'h000, 0, 1);        // R3

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] dev;
      logic [11:0] w;
      logic alt;
      int pick;
      alt  = $urandom_range(1, 0);
      pick = $urandom_range(9, 0);
      if (pick < 4)      dev = 6'o05;
      else if (pick < 7) dev = 6'o15;
      else               dev = 6'($urandom);
      w = mk(dev, 3'($urandom));
      if ($urandom_range(19, 0) == 0) w[11:9] = 3'($urandom);
      doOp(w, 12'($urandom), alt, 1'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule